// File: doc/BRIEF.md
# DAC Output Protection Sequencer

This block drives the two analog switches in the output stage of a voltage-output DAC: a clamp that ties the output pin to ground, and a connect switch that joins the buffer amplifier to that pin. It keeps the pin clamped while supplies are bad or an external active-low reset is asserted. It lets the amplifier drive the pin only after a new DAC word has been loaded while the supplies are good and the reset is released. Every change between the two switch settings uses break-before-make: the switch that opens is released one clock before the other one closes.

It also controls the track/hold mode of the output buffer. A falling edge on the active-low load strobe starts a hold of `HOLD_CYC` clock cycles, which masks the update glitch. It also outputs a registered supply-reset status that other logic can use. The external reset and the load strobe are asynchronous and pass through `SYNC_STAGES`-deep synchronisers. The supply flag and the word-loaded strobe are synchronous to `clk`.

States of the switch FSM:
- `PS_CLAMPED`: clamp closed, connect open.
- `PS_UNCLAMP`: both open.
- `PS_DRIVING`: clamp open, connect closed.
- `PS_DETACH`: both open.

Transitions:
- Arm: `PS_CLAMPED`→`PS_UNCLAMP` on a loaded word with both conditions good.
- Connect: `PS_UNCLAMP`→`PS_DRIVING` when both conditions are still good.
- Abort: `PS_UNCLAMP`→`PS_CLAMPED` when either condition fails.
- Trip: `PS_DRIVING`→`PS_DETACH` when either condition fails.
- Settle: `PS_DETACH`→`PS_CLAMPED`, always.

Top module: `dac_outprot_seq`

## Requirements
- R1: In reset and in the first cycle after reset: clamp_en_o=1, buf_conn_o=0, hold_o=0 and supply_rst_o=1.
- R2: word_valid_i=1 in a cycle where supply_ok_i=1 and the synchronised reset is high drops clamp_en_o after that edge. buf_conn_o then rises one edge later.
- R3: While driving, ext_rst_n_i going low drops buf_conn_o at the (SYNC_STAGES+1)-th edge after the change. clamp_en_o rises one edge later.
- R4: Releasing ext_rst_n_i or restoring supply_ok_i alone leaves clamp_en_o=1 and buf_conn_o=0. A word_valid_i while either condition is bad is ignored.
- R5: While driving, supply_ok_i=0 drops buf_conn_o after the next edge. clamp_en_o rises one edge later.
- R6: clamp_en_o and buf_conn_o are never 1 together. Each switch closes only one cycle after the other has opened.
- R7: supply_rst_o is the inverse of supply_ok_i, registered by one flop.
- R8: A synchronised falling edge of load_n_i raises hold_o at the (SYNC_STAGES+1)-th edge after the change. hold_o stays high for exactly HOLD_CYC cycles.
- R9: A new falling edge of load_n_i during a hold restarts the full HOLD_CYC interval.
- R10: load_n_i held low from reset onward never raises hold_o. A rising edge of load_n_i never raises it either.
- R11: If either condition fails in `PS_UNCLAMP`, the FSM returns to `PS_CLAMPED` without raising buf_conn_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Synchronous supply-good flag |
| ext_rst_n_i | input | 1 | Asynchronous active-low external reset |
| word_valid_i | input | 1 | Synchronous strobe: new DAC word loaded |
| load_n_i | input | 1 | Asynchronous active-low load strobe |
| clamp_en_o | output | 1 | 1 closes the output-to-ground clamp |
| buf_conn_o | output | 1 | 1 connects the amplifier to the output pin |
| hold_o | output | 1 | 1 holds the output buffer, 0 tracks |
| supply_rst_o | output | 1 | Registered supply-reset status, 1 when supplies are bad |

## Verification
The hardest cases to reach from the ports depend on exact synchroniser latency. One is a supply failure that lands in the single `PS_UNCLAMP` cycle. The other is a second load edge that arrives while a hold is already running. Directed sequences count edges from each input change to place these events exactly. A long constrained-random phase then toggles all four inputs at mixed rates, so that aborts, trips and hold restarts occur in many phase relationships. Each cycle is compared against a cycle model written from the requirements.

// File: rtl/dac_prot_pkg.sv
package dac_prot_pkg;
    typedef enum logic [1:0] {
        PS_CLAMPED = 2'd0,
        PS_UNCLAMP = 2'd1,
        PS_DRIVING = 2'd2,
        PS_DETACH  = 2'd3
    } prot_state_e;
endpackage

// File: rtl/dps_sync.sv
module dps_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b0;
                    else        pipe[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= 1'b0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/dps_hold_timer.sv
module dps_hold_timer #(
    parameter int HOLD_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_s_i,
    output logic hold_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);

    logic             load_prev;
    logic             load_edge;
    logic [CNT_W-1:0] cnt;

    // falling edge of the synchronised active-low strobe
    assign load_edge = load_prev && !load_s_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_prev <= 1'b0;
            cnt       <= '0;
        end else begin
            load_prev <= load_s_i;
            if (load_edge)
                cnt <= CNT_W'(HOLD_CYC);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
        end
    end

    assign hold_o = (cnt != '0);

    // R8: an edge reloads the full interval
    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        load_edge |=> (cnt == CNT_W'(HOLD_CYC)));
    // R8: the interval counts down by one per cycle without a new edge
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !load_edge) |=> (cnt == $past(cnt) - 1'b1));
    // R10: the hold starts only from an edge
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !load_edge) |=> (cnt == '0));
endmodule

// File: rtl/dps_switch_fsm.sv
module dps_switch_fsm
    import dac_prot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic ext_ok_i,
    input  logic word_valid_i,
    output logic clamp_o,
    output logic buf_o
);
    prot_state_e state, state_nx;
    logic        cond_ok;

    assign cond_ok = supply_ok_i && ext_ok_i;

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_CLAMPED: if (cond_ok && word_valid_i) state_nx = PS_UNCLAMP;
            PS_UNCLAMP: state_nx = cond_ok ? PS_DRIVING : PS_CLAMPED;
            PS_DRIVING: if (!cond_ok) state_nx = PS_DETACH;
            PS_DETACH:  state_nx = PS_CLAMPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_CLAMPED;
        else        state <= state_nx;
    end

    always_comb begin
        clamp_o = 1'b0;
        buf_o   = 1'b0;
        unique case (state)
            PS_CLAMPED: clamp_o = 1'b1;
            PS_UNCLAMP: ;
            PS_DRIVING: buf_o   = 1'b1;
            PS_DETACH:  ;
        endcase
    end

    // R2: connection only follows a cycle with both conditions good
    a_r2_connect_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_o) |-> $past(cond_ok));
    // R3: a synchronised reset while driving drops the connection next cycle
    a_r3_reset_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DRIVING && !ext_ok_i) |=> !buf_o);
    // R5: supply loss while driving drops the connection next cycle
    a_r5_supply_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DRIVING && !supply_ok_i) |=> !buf_o);
    // R11: a failed condition while unclamping returns to clamped
    a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_UNCLAMP && !cond_ok) |=> (clamp_o && !buf_o));
endmodule

// File: rtl/dac_outprot_seq.sv
module dac_outprot_seq #(
    parameter int HOLD_CYC    = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic ext_rst_n_i,
    input  logic word_valid_i,
    input  logic load_n_i,
    output logic clamp_en_o,
    output logic buf_conn_o,
    output logic hold_o,
    output logic supply_rst_o
);
    logic ext_ok_s;
    logic load_n_s;

    dps_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .d_i(ext_rst_n_i), .q_o(ext_ok_s)
    );

    dps_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
        .clk(clk), .rst_n(rst_n), .d_i(load_n_i), .q_o(load_n_s)
    );

    dps_switch_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_ok_i),
        .ext_ok_i     (ext_ok_s),
        .word_valid_i (word_valid_i),
        .clamp_o      (clamp_en_o),
        .buf_o        (buf_conn_o)
    );

    dps_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk(clk), .rst_n(rst_n), .load_s_i(load_n_s), .hold_o(hold_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) supply_rst_o <= 1'b1;
        else        supply_rst_o <= !supply_ok_i;
    end

    // R6: both switches never closed together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(clamp_en_o && buf_conn_o));
    // R6: connect closes only after the clamp was already open
    a_r6_break_clamp_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_conn_o) |-> $past(!clamp_en_o));
    // R6: clamp closes only after the connect was already open
    a_r6_break_buf_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clamp_en_o) |-> $past(!buf_conn_o));
    // R7: status follows the supply flag by one register
    a_r7_status_bad: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> supply_rst_o);
    a_r7_status_good: assert property (@(posedge clk) disable iff (!rst_n)
        supply_ok_i |=> !supply_rst_o);
endmodule

// File: tb/dac_outprot_seq_tb_top.sv
`timescale 1ns/1ps
module dac_outprot_seq_tb_top;
    localparam int HC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, ext_n = 1'b0, wv = 1'b0, load_n = 1'b1;
    logic clamp, bconn, hold, srst;
    int   n_chk = 0, n_err = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    dac_outprot_seq #(.HOLD_CYC(HC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .ext_rst_n_i(ext_n),
        .word_valid_i(wv), .load_n_i(load_n), .clamp_en_o(clamp),
        .buf_conn_o(bconn), .hold_o(hold), .supply_rst_o(srst)
    );

    // cycle model built from the requirements
    logic mx1, mx2, ml1, ml2, ml3, msr;
    int   mmode, mcnt;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mx1 <= 0; mx2 <= 0; ml1 <= 0; ml2 <= 0; ml3 <= 0;
            msr <= 1; mmode <= 0; mcnt <= 0;
        end else begin
            mx1 <= ext_n; mx2 <= mx1;
            ml1 <= load_n; ml2 <= ml1; ml3 <= ml2;
            msr <= !supply_ok;
            if (ml3 && !ml2) mcnt <= HC;
            else if (mcnt != 0) mcnt <= mcnt - 1;
            case (mmode)
                0: if (supply_ok && mx2 && wv) mmode <= 1;
                1: mmode <= (supply_ok && mx2) ? 2 : 0;
                2: if (!(supply_ok && mx2)) mmode <= 3;
                default: mmode <= 0;
            endcase
        end
    end

    function automatic logic exp_clamp(int m); return m == 0; endfunction
    function automatic logic exp_buf(int m);   return m == 2; endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 clamp in reset", clamp, 1'b1);
        chk("R1 buf in reset", bconn, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 clamp", clamp, 1'b1);
        chk("R1 buf", bconn, 1'b0);
        chk("R1 hold", hold, 1'b0);
        chk("R1 status", srst, 1'b1);
        chk("R10 rising load no hold", hold, 1'b0);

        // supplies and reset good, no word yet
        supply_ok = 1; ext_n = 1;
        repeat (4) step();
        chk("R4 no word keeps clamp", clamp, 1'b1);
        chk("R4 no word keeps buf open", bconn, 1'b0);
        chk("R7 status clears", srst, 1'b0);

        wv = 1; step(); wv = 0;
        chk("R2 clamp opens", clamp, 1'b0);
        chk("R2 buf still open", bconn, 1'b0);
        step();
        chk("R2 buf connects", bconn, 1'b1);

        // external reset while driving
        ext_n = 0; step(); step();
        chk("R3 buf before sync", bconn, 1'b1);
        step();
        chk("R3 buf drops", bconn, 1'b0);
        chk("R3 clamp not yet", clamp, 1'b0);
        step();
        chk("R3 clamp closes", clamp, 1'b1);

        ext_n = 1; repeat (4) step();
        chk("R4 release alone", clamp, 1'b1);
        chk("R4 release alone buf", bconn, 1'b0);

        ext_n = 0; repeat (3) step();
        wv = 1; step(); wv = 0; step();
        chk("R4 word in reset ignored", clamp, 1'b1);
        ext_n = 1; repeat (3) step();
        chk("R4 no latched word", clamp, 1'b1);

        wv = 1; step(); wv = 0; step();
        chk("R2 reconnect", bconn, 1'b1);

        supply_ok = 0; step();
        chk("R5 buf drops", bconn, 1'b0);
        chk("R7 status sets", srst, 1'b1);
        step();
        chk("R5 clamp closes", clamp, 1'b1);

        supply_ok = 1; repeat (2) step();
        chk("R4 supply restore alone", clamp, 1'b1);
        wv = 1; step(); wv = 0; supply_ok = 0;
        chk("R11 in unclamp", clamp, 1'b0);
        step();
        chk("R11 abort clamp", clamp, 1'b1);
        chk("R11 abort buf", bconn, 1'b0);
        step();
        chk("R11 stays open", bconn, 1'b0);
        supply_ok = 1;

        // hold timing and restart
        load_n = 1; repeat (4) step();
        load_n = 0;
        for (int i = 1; i <= 24; i++) begin
            step();
            if (i == 2)  chk("R8 not yet", hold, 1'b0);
            if (i == 3)  chk("R8 hold starts", hold, 1'b1);
            if (i == 7)  load_n = 1;
            if (i == 9)  load_n = 0;
            if (i == 15) chk("R9 restarted past first end", hold, 1'b1);
            if (i == 23) chk("R9 last held cycle", hold, 1'b1);
            if (i == 24) chk("R9 returns to track", hold, 1'b0);
        end
        load_n = 1; repeat (4) step();
        load_n = 0;
        for (int i = 1; i <= 16; i++) begin
            step();
            if (i == 14) chk("R8 last cycle of hold", hold, 1'b1);
            if (i == 15) chk("R8 hold length", hold, 1'b0);
        end

        // load held low through reset and after
        rst_n = 0; step(); rst_n = 1;
        for (int i = 0; i < 30; i++) begin
            step();
            if (i % 10 == 0) chk("R10 permanent low no hold", hold, 1'b0);
        end

        // constrained random phase against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 64 == 0) supply_ok = !supply_ok;
            if ($urandom % 48 == 0) ext_n = !ext_n;
            wv = ($urandom % 8 == 0);
            if ($urandom % 6 == 0) load_n = !load_n;
            step();
            chk("R2/R3/R5 clamp vs model", clamp, exp_clamp(mmode));
            chk("R2/R3/R5 buf vs model", bconn, exp_buf(mmode));
            chk("R8 hold vs model", hold, mcnt != 0);
            chk("R7 status vs model", srst, msr);
            chk("R6 exclusive", clamp && bconn, 1'b0);
        end

        done = 1;
        summary();
        $finish;
    end
endmodule